// File: doc/BRIEF.md
# SPI Command and Interrupt Status Controller

This block sits behind an SPI slave that has already assembled 8-bit frames (MSB first). It recognises a small set of general control commands and handles them locally; such frames never reach the data FIFO. Every other frame is a driver command, and this block does not act on it. The block watches the FIFO fill level and the fault, overtemperature, reset-pin and supply-valid signals. It latches interrupt events into a pending status set and holds an active-high IRQ line while any event is pending.

Each accepted frame loads a reply word that is shifted out on MISO during the following frame. Query commands return the status word, the driver setup or the sticky fault register. All other frames return zero. The block also keeps the modulator speed flag and a halt flag. From these and the fault register it drives an operability flag and a driver-command enable that the driver command path must obey.

Top module: `cmdStatusCtrl`

## Requirements
- R1: Command encodings: 0xC0 get status, 0xC1 get driver setup, 0xC2 get fault info, 0xC3 reset fault status, 0xD0/0xD1 set SPI config (bit 0 is the requested speed), 0xE0 halt. Any other byte is a driver command and changes none of this block's state.
- R2: After reset the R bit is pending and irq is high, the fault register is empty, speed is normal (0), the block is not halted and misoWord is 0.
- R3: The status word is {R, F, T, BO, BU, S, Op, 0} from bit 7 down to bit 0. The reply to a frame appears on misoWord on the clock after the frame is accepted and holds until the next frame. A status reply shows the pending bits as they stood when the frame was accepted.
- R4: irq is high exactly while any pending bit is set. Get status clears every pending bit except one whose event arrives in the same cycle.
- R5: F is set by a rising edge on any fault input, T by a rising edge of overTemp and R by a falling edge of pinResetN. A source held asserted does not set its bit again.
- R6: BU is set when fifoLevel moves from above 4 to 4 or less. BO is set when fifoLevel moves from 16 or less to above 16.
- R7: Bit i of the fault register is set by a rising edge of faultIn[i]. Get fault info replies with the register zero-extended to 8 bits and does not clear it or the IRQ.
- R8: Reset fault status clears the fault register. A fault edge in the same cycle wins.
- R9: operable is 1 only when the fault register is empty and every supplyOk bit is 1.
- R10: drvCmdEn equals operable while not halted. Halt forces it low until the next set SPI config; other commands do not release it.
- R11: Set SPI config loads S from frame bit 0. Get driver setup replies {5'b0, halted, S, Op}.
- R12: Every frame other than the three query commands loads a reply of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| frameValid | input | 1 | One-cycle strobe: a received frame is present |
| frameData | input | 8 | Received frame byte |
| fifoLevel | input | LEVEL_W | Data FIFO fill count |
| faultIn | input | NUM_FAULT | Driver stage fault flags, one per stage |
| overTemp | input | 1 | Chip overtemperature flag |
| pinResetN | input | 1 | External active-low reset pin level |
| supplyOk | input | NUM_SUPPLY | Supply-valid flags |
| irq | output | 1 | Interrupt request, active high |
| misoWord | output | 8 | Reply word for the next frame |
| operable | output | 1 | Operability flag |
| drvCmdEn | output | 1 | Driver-command enable |

## Verification
The hardest case to reach is an event that arrives in the same cycle as the command that would erase it. Examples are an overtemperature edge during a status read, or a fault edge during a reset-fault command. The bench drives the source change and the frame strobe on the same falling clock edge so both land on one rising edge. It then reads back to check that the event survived and that the earlier reply did not include it. The FIFO threshold logic is checked with every ordered pair of fill levels from 0 to 20. Expected BU and BO values come from the two threshold comparisons.

// File: rtl/cmdStatusPkg.sv
package cmdStatusPkg;
  localparam logic [7:0] OP_GET_STATUS = 8'hC0;
  localparam logic [7:0] OP_GET_SETUP  = 8'hC1;
  localparam logic [7:0] OP_GET_FAULT  = 8'hC2;
  localparam logic [7:0] OP_CLR_FAULT  = 8'hC3;
  localparam logic [6:0] OP_SET_CFG_HI = 7'b1101_000;
  localparam logic [7:0] OP_HALT       = 8'hE0;

  typedef struct packed {
    logic anyFrame;
    logic getStatus;
    logic getSetup;
    logic getFault;
    logic clrFault;
    logic setCfg;
    logic cfgSpeed;
    logic halt;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    REPLY_ZERO   = 2'd0,
    REPLY_STATUS = 2'd1,
    REPLY_SETUP  = 2'd2,
    REPLY_FAULT  = 2'd3
  } replySel_t;
endpackage

// File: rtl/edgeLatch.sv
module edgeLatch #(
  parameter int W       = 1,
  parameter bit FALLING = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] sig,
  output logic [W-1:0] evt
);
  logic [W-1:0] prevSig;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSig <= FALLING ? {W{1'b1}} : {W{1'b0}};
    else       prevSig <= sig;
  end

  generate
    if (FALLING) begin : g_fall
      assign evt = prevSig & ~sig;
    end else begin : g_rise
      assign evt = sig & ~prevSig;
    end
  endgenerate
endmodule

// File: rtl/levelCross.sv
module levelCross #(
  parameter int LEVEL_W   = 6,
  parameter int LOW_MARK  = 4,
  parameter int HIGH_MARK = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] level,
  output logic               underEvt,
  output logic               overEvt
);
  localparam logic [LEVEL_W-1:0] LOW_L  = LEVEL_W'(LOW_MARK);
  localparam logic [LEVEL_W-1:0] HIGH_L = LEVEL_W'(HIGH_MARK);

  logic [LEVEL_W-1:0] prevLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= '0;
    else       prevLevel <= level;
  end

  assign underEvt = (prevLevel > LOW_L) && (level <= LOW_L);
  assign overEvt  = (prevLevel <= HIGH_L) && (level > HIGH_L);
endmodule

// File: rtl/cmdCtrl.sv
module cmdCtrl
  import cmdStatusPkg::*;
(
  input  logic        frameValid,
  input  logic [7:0]  frameData,
  output ctrlStrobe_t strb,
  output replySel_t   replySel
);
  always_comb begin
    strb           = '0;
    replySel       = REPLY_ZERO;
    strb.anyFrame  = frameValid;
    strb.cfgSpeed  = frameData[0];
    if (frameValid) begin
      unique case (frameData)
        OP_GET_STATUS: begin strb.getStatus = 1'b1; replySel = REPLY_STATUS; end
        OP_GET_SETUP:  begin strb.getSetup  = 1'b1; replySel = REPLY_SETUP;  end
        OP_GET_FAULT:  begin strb.getFault  = 1'b1; replySel = REPLY_FAULT;  end
        OP_CLR_FAULT:  strb.clrFault = 1'b1;
        OP_HALT:       strb.halt     = 1'b1;
        default: begin
          if (frameData[7:1] == OP_SET_CFG_HI) strb.setCfg = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/statusDatapath.sv
module statusDatapath
  import cmdStatusPkg::*;
#(
  parameter int NUM_FAULT  = 6,
  parameter int NUM_SUPPLY = 3,
  parameter int LEVEL_W    = 6,
  parameter int LOW_MARK   = 4,
  parameter int HIGH_MARK  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strb,
  input  replySel_t             replySel,
  input  logic [LEVEL_W-1:0]    fifoLevel,
  input  logic [NUM_FAULT-1:0]  faultIn,
  input  logic                  overTemp,
  input  logic                  pinResetN,
  input  logic [NUM_SUPPLY-1:0] supplyOk,
  output logic                  irq,
  output logic [7:0]            misoWord,
  output logic                  operable,
  output logic                  drvCmdEn
);
  localparam int NUM_SRC = 5;

  logic [NUM_FAULT-1:0] faultRise;
  logic                 tempRise;
  logic                 pinFall;
  logic                 underEvt;
  logic                 overEvt;

  edgeLatch #(.W(NUM_FAULT), .FALLING(1'b0)) faultEdge_i (
    .clk(clk), .rstN(rstN), .sig(faultIn), .evt(faultRise));
  edgeLatch #(.W(1), .FALLING(1'b0)) tempEdge_i (
    .clk(clk), .rstN(rstN), .sig(overTemp), .evt(tempRise));
  edgeLatch #(.W(1), .FALLING(1'b1)) pinEdge_i (
    .clk(clk), .rstN(rstN), .sig(pinResetN), .evt(pinFall));
  levelCross #(.LEVEL_W(LEVEL_W), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) lvl_i (
    .clk(clk), .rstN(rstN), .level(fifoLevel), .underEvt(underEvt), .overEvt(overEvt));

  // pending order: R, F, T, BO, BU
  logic [NUM_SRC-1:0]   pending;
  logic [NUM_SRC-1:0]   newEvt;
  logic [NUM_FAULT-1:0] faultReg;
  logic                 speedHigh;
  logic                 halted;

  assign newEvt = {pinFall, |faultRise, tempRise, overEvt, underEvt};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= {1'b1, {(NUM_SRC-1){1'b0}}};
    else       pending <= (strb.getStatus ? '0 : pending) | newEvt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultReg <= '0;
    else       faultReg <= (strb.clrFault ? '0 : faultReg) | faultRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      speedHigh <= 1'b0;
      halted    <= 1'b0;
    end else begin
      if (strb.setCfg) speedHigh <= strb.cfgSpeed;
      if (strb.halt)        halted <= 1'b1;
      else if (strb.setCfg) halted <= 1'b0;
    end
  end

  assign operable = ~|faultReg & &supplyOk;
  assign drvCmdEn = operable & ~halted;
  assign irq      = |pending;

  logic [7:0] statusWord;
  logic [7:0] setupWord;
  logic [7:0] faultWord;
  logic [7:0] replyWord;

  assign statusWord = {pending, speedHigh, operable, 1'b0};
  assign setupWord  = {5'b0, halted, speedHigh, operable};

  always_comb begin
    faultWord = '0;
    for (int i = 0; i < NUM_FAULT; i++) faultWord[i] = faultReg[i];
  end

  always_comb begin
    unique case (replySel)
      REPLY_STATUS: replyWord = statusWord;
      REPLY_SETUP:  replyWord = setupWord;
      REPLY_FAULT:  replyWord = faultWord;
      default:      replyWord = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              misoWord <= 8'h00;
    else if (strb.anyFrame) misoWord <= replyWord;
  end
endmodule

// File: rtl/cmdStatusCtrl.sv
module cmdStatusCtrl
  import cmdStatusPkg::*;
#(
  parameter int NUM_FAULT  = 6,
  parameter int NUM_SUPPLY = 3,
  parameter int LEVEL_W    = 6,
  parameter int LOW_MARK   = 4,
  parameter int HIGH_MARK  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameValid,
  input  logic [7:0]            frameData,
  input  logic [LEVEL_W-1:0]    fifoLevel,
  input  logic [NUM_FAULT-1:0]  faultIn,
  input  logic                  overTemp,
  input  logic                  pinResetN,
  input  logic [NUM_SUPPLY-1:0] supplyOk,
  output logic                  irq,
  output logic [7:0]            misoWord,
  output logic                  operable,
  output logic                  drvCmdEn
);
  ctrlStrobe_t strb;
  replySel_t   replySel;

  cmdCtrl ctrl_i (
    .frameValid(frameValid), .frameData(frameData), .strb(strb), .replySel(replySel));

  statusDatapath #(
    .NUM_FAULT(NUM_FAULT), .NUM_SUPPLY(NUM_SUPPLY), .LEVEL_W(LEVEL_W),
    .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .replySel(replySel),
    .fifoLevel(fifoLevel), .faultIn(faultIn), .overTemp(overTemp),
    .pinResetN(pinResetN), .supplyOk(supplyOk), .irq(irq),
    .misoWord(misoWord), .operable(operable), .drvCmdEn(drvCmdEn));
endmodule

// File: rtl/cmdStatusCtrlChk.sv
module cmdStatusCtrlChk
  import cmdStatusPkg::*;
#(
  parameter int NUM_SUPPLY = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  frameValid,
  input logic [7:0]            frameData,
  input logic [NUM_SUPPLY-1:0] supplyOk,
  input logic [7:0]            misoWord,
  input logic                  operable,
  input logic                  drvCmdEn
);
  a_r9_supply_gate: assert property (@(posedge clk) disable iff (!rstN)
    !(&supplyOk) |-> !operable);

  a_r10_enable_needs_op: assert property (@(posedge clk) disable iff (!rstN)
    drvCmdEn |-> operable);

  a_r10_halt_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameData == OP_HALT) |=> !drvCmdEn);

  a_r3_reply_holds: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |=> $stable(misoWord));

  a_r12_driver_frame_zero: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameData[7:6] != 2'b11) |=> (misoWord == 8'h00));
endmodule

bind cmdStatusCtrl cmdStatusCtrlChk #(.NUM_SUPPLY(NUM_SUPPLY)) chk_i (.*);

// File: tb/cmdStatusCtrl_tb_top.sv
module cmdStatusCtrl_tb_top;
  localparam int NF = 6;
  localparam int NS = 3;
  localparam int LW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          frameValid = 1'b0;
  logic [7:0]    frameData = 8'h00;
  logic [LW-1:0] fifoLevel = '0;
  logic [NF-1:0] faultIn = '0;
  logic          overTemp = 1'b0;
  logic          pinResetN = 1'b1;
  logic [NS-1:0] supplyOk = '1;
  logic          irq;
  logic [7:0]    misoWord;
  logic          operable;
  logic          drvCmdEn;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  cmdStatusCtrl dut_i (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameData(frameData),
    .fifoLevel(fifoLevel), .faultIn(faultIn), .overTemp(overTemp),
    .pinResetN(pinResetN), .supplyOk(supplyOk), .irq(irq),
    .misoWord(misoWord), .operable(operable), .drvCmdEn(drvCmdEn));

  task automatic check(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic sendFrame(input logic [7:0] d);
    frameValid = 1'b1;
    frameData  = d;
    @(negedge clk);
    frameValid = 1'b0;
    frameData  = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2 irq", irq, 1);
    check("R2 miso", misoWord, 0);
    check("R2 operable", operable, 1);
    check("R2 drvCmdEn", drvCmdEn, 1);
    sendFrame(8'hC0);
    check("R2 R3 status after reset", misoWord, 8'h82);
    check("R4 irq cleared", irq, 0);
    sendFrame(8'hC1);
    check("R2 R11 setup after reset", misoWord, 8'h01);

    // R6 threshold sweep over ordered level pairs
    for (int a = 0; a <= 20; a++) begin
      for (int b = 0; b <= 20; b++) begin
        int bu;
        int bo;
        fifoLevel = LW'(a);
        @(negedge clk);
        sendFrame(8'hC0);
        fifoLevel = LW'(b);
        @(negedge clk);
        bu = (a > 4 && b <= 4) ? 1 : 0;
        bo = (a <= 16 && b > 16) ? 1 : 0;
        check("R4 R6 irq after level move", irq, bu | bo);
        sendFrame(8'hC0);
        check("R6 status after level move", misoWord, (bo << 4) | (bu << 3) | 2);
      end
    end
    fifoLevel = '0;
    @(negedge clk);
    sendFrame(8'hC0);

    // R5 R7 R8 R9 fault pattern sweep
    for (int p = 1; p < (1 << NF); p++) begin
      faultIn = NF'(p);
      @(negedge clk);
      check("R5 irq on fault", irq, 1);
      check("R9 operable with fault", operable, 0);
      check("R10 enable with fault", drvCmdEn, 0);
      sendFrame(8'hC2);
      check("R7 fault reply", misoWord, p);
      check("R7 fault read keeps irq", irq, 1);
      sendFrame(8'hC0);
      check("R3 R5 status with fault", misoWord, 8'h40);
      sendFrame(8'hC0);
      check("R5 held fault no retrigger", misoWord, 8'h00);
      sendFrame(8'hC3);
      check("R8 operable after clear", operable, 1);
      sendFrame(8'hC2);
      check("R8 fault reg cleared", misoWord, 0);
      faultIn = '0;
      @(negedge clk);
      check("R5 falling fault no irq", irq, 0);
    end

    // R9 supply sweep
    for (int s = 0; s < (1 << NS); s++) begin
      supplyOk = NS'(s);
      @(negedge clk);
      check("R9 operable vs supplies", operable, (s == 7) ? 1 : 0);
      check("R10 enable vs supplies", drvCmdEn, (s == 7) ? 1 : 0);
    end
    supplyOk = '1;
    @(negedge clk);

    // R4 event in same cycle as status read
    overTemp = 1'b1;
    sendFrame(8'hC0);
    check("R4 reply excludes same-cycle T", misoWord, 8'h02);
    check("R4 same-cycle event keeps irq", irq, 1);
    sendFrame(8'hC0);
    check("R5 T latched", misoWord, 8'h22);
    overTemp = 1'b0;
    @(negedge clk);

    // R8 fault edge wins over clear in same cycle
    faultIn = 6'b000001;
    sendFrame(8'hC3);
    sendFrame(8'hC2);
    check("R8 same-cycle fault wins", misoWord, 1);
    faultIn = '0;
    @(negedge clk);
    sendFrame(8'hC3);
    sendFrame(8'hC0);
    check("R5 R8 status after clear", misoWord, 8'h42);

    // R5 reset pin falling edge
    pinResetN = 1'b0;
    @(negedge clk);
    check("R5 irq on pin reset", irq, 1);
    sendFrame(8'hC0);
    check("R5 R bit from pin", misoWord, 8'h82);
    sendFrame(8'hC0);
    check("R5 held pin no retrigger", misoWord, 8'h02);
    pinResetN = 1'b1;
    @(negedge clk);
    sendFrame(8'hC0);
    check("R5 pin release no event", misoWord, 8'h02);

    // R10 R11 R12 halt, config, driver frames
    sendFrame(8'hE0);
    check("R10 halt drops enable", drvCmdEn, 0);
    sendFrame(8'hC1);
    check("R11 setup while halted", misoWord, 8'h05);
    sendFrame(8'h12);
    check("R12 driver frame reply zero", misoWord, 0);
    check("R1 driver frame keeps halt", drvCmdEn, 0);
    sendFrame(8'hC3);
    check("R10 clear fault keeps halt", drvCmdEn, 0);
    check("R12 clear fault reply zero", misoWord, 0);
    sendFrame(8'hD1);
    check("R10 set config releases halt", drvCmdEn, 1);
    sendFrame(8'hC0);
    check("R11 S in status", misoWord, 8'h06);
    sendFrame(8'hC1);
    check("R11 setup high speed", misoWord, 8'h03);
    repeat (2) @(negedge clk);
    check("R3 reply holds between frames", misoWord, 8'h03);
    sendFrame(8'hD0);
    sendFrame(8'hC1);
    check("R11 setup normal speed", misoWord, 8'h01);
    sendFrame(8'hBF);
    check("R1 near-code frame is driver", misoWord, 0);
    check("R1 near-code no irq", irq, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule